// File: doc/BRIEF.md
# I2C Paged EEPROM Slave Controller

This block is the byte-level engine of an I2C memory slave. A bus front end outside the block turns the SDA and SCL pins into single-cycle events: a start or repeated start, a stop, a completed byte from the master, and the master's acknowledge bit after a byte the slave sent. The controller answers each received byte with an ACK or NACK decision. During reads it supplies the next byte to shift out. Behind it sits a small byte array that plays the part of the EEPROM cells, organized in 16-byte pages and filled with FFh at reset.

The master can write one byte, or up to a full page, after a one-byte word address. A random read is a dummy write of the word address followed by a repeated start in the read direction. A current-address read continues from the internal pointer. A sequential read keeps streaming bytes for as long as the master acknowledges. Written bytes are staged and go to the array only at the closing stop. A self-timed write cycle then begins, and it is modelled with a cycle counter. While that cycle runs, the device refuses its address. A full-array write-protect input blocks data bytes. A dedicated probe byte, 63h, reports the protection state through its acknowledge.

Top module: `eep_slave_ctrl`

## Requirements
- R1: After reset, ack_vld, ack_o, tx_vld and busy are 0, the internal pointer is 0, and every array byte reads FFh.
- R2: A byte received right after a start is ACKed (ack_vld=1, ack_o=1 one cycle after ev_byte) when bits 7:1 equal DEV_ID. Bit 0 selects the direction: 0 write, 1 read. Any other byte in that position is NACKed, and all later bytes are NACKed until the next start.
- R3: In a write, the first byte after the address is the word address and is always ACKed. Each following data byte is ACKed and loaded at the pointer. The pointer then advances with only its low 4 bits wrapping, so bytes past the end of the page land at the start of the same page. Bytes reach the array only at the stop.
- R4: A stop that closes a write with at least one accepted data byte raises busy in the next cycle, and busy stays high for exactly WR_CYCLES cycles. A stop after only the address byte or the word address leaves busy low.
- R5: While busy is high, the device address and the probe byte are NACKed.
- R6: A repeated start after the word address (dummy write) commits nothing and starts no write cycle. The read that follows returns the byte at that word address.
- R7: After a read address is ACKed, tx_vld pulses with the byte at the pointer in the same cycle as the ACK. Each master ACK (mack_nack=0) loads the next byte one cycle later. The pointer runs from the last array byte back to address 0.
- R8: A master NACK (mack_nack=1) loads no further byte, and later bytes are NACKed until the next start.
- R9: A read-direction address with no preceding dummy write returns the byte at the internal pointer. The pointer sits one past the last byte transmitted, or one past the last byte loaded in a write (page-wrapped).
- R10: The probe byte 63h right after a start is ACKed when wp_en is 0 and NACKed when wp_en is 1.
- R11: With wp_en high, data bytes are NACKed, nothing is committed and busy stays low. The word address is still ACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | Start or repeated start seen (one-cycle pulse) |
| ev_stop | input | 1 | Stop seen (one-cycle pulse) |
| ev_byte | input | 1 | A byte from the master is complete (one-cycle pulse) |
| rx_byte | input | 8 | The received byte, valid with ev_byte |
| ev_mack | input | 1 | Master acknowledge bit after a transmitted byte (pulse) |
| mack_nack | input | 1 | 1 = master NACK, 0 = master ACK, valid with ev_mack |
| wp_en | input | 1 | Full-array write protect |
| ack_vld | output | 1 | Acknowledge decision valid (pulse) |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| tx_vld | output | 1 | A new byte to transmit is loaded (pulse) |
| tx_o | output | 8 | Byte to transmit |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Every acknowledge decision appears one clock after its ev_byte pulse. Each transmit byte appears one clock after the ev_byte or ev_mack that requests it. busy rises one clock after the committing stop. The bench drives each event for one cycle from the falling edge, passes one rising edge, and samples on the next falling edge, so each result is read in the cycle it is due. Write-cycle length is measured by counting sampled busy cycles from that first sample until busy falls, and the count is compared with WR_CYCLES.

// File: rtl/eep_pkg.sv
package eep_pkg;

  // Transaction phase of the slave engine
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // between transactions
    ST_ADDR  = 3'd1,  // expecting the address / probe byte
    ST_WADDR = 3'd2,  // expecting the word address
    ST_WDATA = 3'd3,  // loading page data
    ST_READ  = 3'd4,  // transmitting
    ST_HOLD  = 3'd5   // refused: NACK everything until a start
  } eep_state_e;

endpackage

// File: rtl/eep_pagebuf.sv
module eep_pagebuf #(
  parameter int PAGE_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          ld,
  input  logic [PAGE_W-1:0]             ld_col,
  input  logic [7:0]                    ld_data,
  output logic [(1<<PAGE_W)*8-1:0]      data,
  output logic [(1<<PAGE_W)-1:0]        mask,
  output logic                          any
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_col
    logic hit;
    assign hit = ld && (ld_col == PAGE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask[g]          <= 1'b0;
        data[g*8 +: 8]   <= 8'h00;
      end else if (clr) begin
        mask[g]          <= 1'b0;
      end else if (hit) begin
        mask[g]          <= 1'b1;
        data[g*8 +: 8]   <= ld_data;
      end
    end
  end

  assign any = |mask;

endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit,
  input  logic [ADDR_W-PAGE_W-1:0]      commit_page,
  input  logic [(1<<PAGE_W)*8-1:0]      wdata,
  input  logic [(1<<PAGE_W)-1:0]        wmask,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [7:0]                    rd_data
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int c = 0; c < PAGE_BYTES; c++) begin
        if (wmask[c]) mem[{commit_page, PAGE_W'(c)}] <= wdata[c*8 +: 8];
      end
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
  parameter int WR_CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (start)          remain <= CW'(WR_CYCLES);
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

  // Checker-side run length of the current busy window
  logic [CW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_len <= '0;
    else if (busy)  run_len <= run_len + 1'b1;
    else            run_len <= '0;
  end

  assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(run_len) == CW'(WR_CYCLES - 1)));

  assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

endmodule

// File: rtl/eep_slave_ctrl.sv
module eep_slave_ctrl #(
  parameter logic [6:0] DEV_ID    = 7'h50,
  parameter logic [7:0] PROBE     = 8'h63,
  parameter int         ADDR_W    = 8,
  parameter int         PAGE_W    = 4,
  parameter int         WR_CYCLES = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_byte,
  input  logic [7:0] rx_byte,
  input  logic       ev_mack,
  input  logic       mack_nack,
  input  logic       wp_en,
  output logic       ack_vld,
  output logic       ack_o,
  output logic       tx_vld,
  output logic [7:0] tx_o,
  output logic       busy
);
  import eep_pkg::*;

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PG_IDX_W   = ADDR_W - PAGE_W;

  // Pointer arithmetic
  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + 1'b1};
  endfunction

  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  eep_state_e        st, st_n;
  logic [ADDR_W-1:0] ptr, ptr_n;
  logic              ack_n, tx_ld;

  // Named internal events
  logic ev_addr_hit, ev_probe, ev_data_ok, ev_data_wp, ev_commit;
  logic pb_clr, pb_any;
  logic [PAGE_BYTES*8-1:0] pb_data;
  logic [PAGE_BYTES-1:0]   pb_mask;
  logic [7:0]              rd_data;

  logic in_addr, in_wdata;
  assign in_addr     = ev_byte && (st == ST_ADDR);
  assign in_wdata    = ev_byte && (st == ST_WDATA);
  assign ev_probe    = in_addr && (rx_byte == PROBE);
  assign ev_addr_hit = in_addr && !ev_probe && (rx_byte[7:1] == DEV_ID) && !busy;
  assign ev_data_ok  = in_wdata && !wp_en;
  assign ev_data_wp  = in_wdata && wp_en;
  assign ev_commit   = ev_stop && (st == ST_WDATA) && pb_any;

  always_comb begin
    st_n   = st;
    ptr_n  = ptr;
    ack_n  = 1'b0;
    tx_ld  = 1'b0;
    pb_clr = 1'b0;
    if (ev_start) begin
      st_n   = ST_ADDR;
      pb_clr = 1'b1;
    end else if (ev_stop) begin
      st_n   = ST_IDLE;
      pb_clr = 1'b1;
    end else if (ev_byte) begin
      case (st)
        ST_ADDR: begin
          if (ev_probe) begin
            ack_n = !wp_en && !busy;
            st_n  = ST_HOLD;
          end else if (ev_addr_hit) begin
            ack_n = 1'b1;
            if (rx_byte[0]) begin
              st_n  = ST_READ;
              tx_ld = 1'b1;
              ptr_n = seq_next(ptr);
            end else begin
              st_n  = ST_WADDR;
            end
          end else begin
            st_n = ST_HOLD;
          end
        end
        ST_WADDR: begin
          ack_n = 1'b1;
          ptr_n = rx_byte[ADDR_W-1:0];
          st_n  = ST_WDATA;
        end
        ST_WDATA: begin
          if (ev_data_wp) begin
            st_n = ST_HOLD;
          end else begin
            ack_n = 1'b1;
            ptr_n = page_next(ptr);
          end
        end
        ST_READ: st_n = ST_HOLD;
        default: st_n = st;
      endcase
    end else if (ev_mack && (st == ST_READ)) begin
      if (!mack_nack) begin
        tx_ld = 1'b1;
        ptr_n = seq_next(ptr);
      end else begin
        st_n = ST_HOLD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ptr     <= '0;
      ack_vld <= 1'b0;
      ack_o   <= 1'b0;
      tx_vld  <= 1'b0;
      tx_o    <= 8'h00;
    end else begin
      st      <= st_n;
      ptr     <= ptr_n;
      ack_vld <= ev_byte;
      ack_o   <= ack_n;
      tx_vld  <= tx_ld;
      if (tx_ld) tx_o <= rd_data;
    end
  end

  eep_pagebuf #(.PAGE_W(PAGE_W)) u_pagebuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (pb_clr),
    .ld      (ev_data_ok),
    .ld_col  (ptr[PAGE_W-1:0]),
    .ld_data (rx_byte),
    .data    (pb_data),
    .mask    (pb_mask),
    .any     (pb_any)
  );

  eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (ev_commit),
    .commit_page (ptr[ADDR_W-1:PAGE_W]),
    .wdata       (pb_data),
    .wmask       (pb_mask),
    .rd_addr     (ptr),
    .rd_data     (rd_data)
  );

  eep_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ev_commit),
    .busy  (busy)
  );

  // Assertions next to the logic they guard
  assert_ack_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte |=> ack_vld);

  assert_busy_nack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte && (st == ST_ADDR) && busy) |=> (ack_vld && !ack_o));

  assert_wp_nack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte && (st == ST_WDATA) && wp_en) |=> (ack_vld && !ack_o));

  assert_commit_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |-> !busy);

  assert_tx_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld |-> (st == ST_READ));

  assert_hold_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte && (st == ST_HOLD)) |=> !ack_o);

endmodule

// File: tb/eep_slave_ctrl_test.sv
module eep_slave_ctrl_test;
  localparam int WRC = 40;
  localparam logic [7:0] CW_W = 8'hA0;
  localparam logic [7:0] CW_R = 8'hA1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start = 0, ev_stop = 0, ev_byte = 0, ev_mack = 0, mack_nack = 0, wp_en = 0;
  logic [7:0] rx_byte = 8'h00;
  logic ack_vld, ack_o, tx_vld, busy;
  logic [7:0] tx_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mdl [256];
  logic [7:0] m_ptr;

  always #5 clk = ~clk;

  eep_slave_ctrl #(.WR_CYCLES(WRC)) uut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_byte(ev_byte), .rx_byte(rx_byte), .ev_mack(ev_mack), .mack_nack(mack_nack),
    .wp_en(wp_en), .ack_vld(ack_vld), .ack_o(ack_o), .tx_vld(tx_vld), .tx_o(tx_o),
    .busy(busy)
  );

  function automatic logic [7:0] pg_step(input logic [7:0] a);
    logic [7:0] r;
    r = a;
    r[3:0] = a[3:0] + 4'd1;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_start();
    ev_start = 1; step(); ev_start = 0;
  endtask

  task automatic do_stop();
    ev_stop = 1; step(); ev_stop = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit exp, input string tag);
    rx_byte = b; ev_byte = 1; step(); ev_byte = 0;
    chk(ack_vld && (ack_o == exp), tag, {ack_vld, ack_o}, {1'b1, exp});
  endtask

  task automatic expect_tx(input string tag);
    chk(tx_vld && (tx_o == mdl[m_ptr]), tag, {tx_vld, tx_o}, {1'b1, mdl[m_ptr]});
    m_ptr = m_ptr + 8'd1;
  endtask

  task automatic mack(input bit n);
    mack_nack = n; ev_mack = 1; step(); ev_mack = 0;
  endtask

  // After a stop: measure the busy window
  task automatic check_busy_window(input bit expect_cycle, input string tag);
    int n;
    if (!expect_cycle) begin
      chk(busy == 1'b0, tag, busy, 0);
      return;
    end
    n = busy ? 1 : 0;
    while (busy) begin
      step();
      if (busy) n++;
    end
    chk(n == WRC, tag, n, WRC);
  endtask

  task automatic page_write(input logic [7:0] addr, input int len, input string tag);
    logic [7:0] pv [256];
    bit         pm [256];
    bit         any;
    logic [7:0] a;
    logic [7:0] d;
    any = 0;
    for (int i = 0; i < 256; i++) pm[i] = 0;
    do_start();
    send(CW_W, 1, "R2 write address");
    send(addr, 1, "R3 word address");
    m_ptr = addr;
    a = addr;
    for (int i = 0; i < len; i++) begin
      d = 8'($urandom);
      send(d, !wp_en, wp_en ? "R11 protected data NACK" : "R3 data ACK");
      if (wp_en) break;
      pv[a] = d; pm[a] = 1; any = 1;
      a = pg_step(a);
    end
    if (!wp_en) m_ptr = a;
    do_stop();
    for (int i = 0; i < 256; i++) if (pm[i]) mdl[i] = pv[i];
    check_busy_window(any, tag);
  endtask

  task automatic random_read(input logic [7:0] addr, input int n);
    do_start();
    send(CW_W, 1, "R6 dummy write address");
    send(addr, 1, "R6 word address");
    m_ptr = addr;
    do_start();
    send(CW_R, 1, "R6 read address");
    expect_tx("R6 random read data");
    for (int i = 1; i < n; i++) begin
      mack(0);
      expect_tx("R7 sequential data");
    end
    mack(1);
    chk(!tx_vld, "R8 no byte after master NACK", tx_vld, 0);
    do_stop();
    chk(!busy, "R6 no write cycle after dummy write", busy, 0);
  endtask

  task automatic cur_read(input int n);
    do_start();
    send(CW_R, 1, "R9 current read address");
    expect_tx("R9 current address data");
    for (int i = 1; i < n; i++) begin
      mack(0);
      expect_tx("R7 sequential data");
    end
    mack(1);
    do_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
    m_ptr = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    chk(!ack_vld && !ack_o && !tx_vld && !busy, "R1 reset outputs",
        {ack_vld, ack_o, tx_vld, busy}, 0);
    cur_read(3);  // R1 array FFh from pointer 0, R9

    // R2: foreign address refused, rest of transaction NACKed
    do_start();
    send(8'hB0, 0, "R2 foreign address NACK");
    send(8'h10, 0, "R2 following byte NACK");
    do_stop();

    // R3: page write wrapping within page
    page_write(8'h3C, 6, "R4 busy window after page write");
    random_read(8'h30, 16);

    // R4: stop after only addresses starts no write cycle
    do_start(); send(CW_W, 1, "R2 write address"); do_stop();
    chk(!busy, "R4 stop after address only", busy, 0);
    do_start(); send(CW_W, 1, "R2 write address"); send(8'h20, 1, "R3 word address");
    do_stop();
    chk(!busy, "R4 stop after word address only", busy, 0);
    m_ptr = 8'h20;

    // R5: busy refuses address and probe
    do_start(); send(CW_W, 1, "R2 write address"); send(8'h50, 1, "R3 word address");
    send(8'h5A, 1, "R3 data ACK");
    do_stop();
    mdl[8'h50] = 8'h5A; m_ptr = 8'h51;
    chk(busy, "R4 busy after stop", busy, 1);
    do_start(); send(CW_R, 0, "R5 address NACK while busy"); do_stop();
    do_start(); send(8'h63, 0, "R5 probe NACK while busy"); do_stop();
    while (busy) step();
    random_read(8'h50, 1);

    // R10: probe
    wp_en = 0;
    do_start(); send(8'h63, 1, "R10 probe ACK unprotected"); do_stop();
    wp_en = 1;
    do_start(); send(8'h63, 0, "R10 probe NACK protected"); do_stop();

    // R11: protected writes
    page_write(8'h50, 3, "R11 no write cycle when protected");
    random_read(8'h50, 2);
    wp_en = 0;

    // R7: sequential wrap from last byte to 0
    page_write(8'hFE, 2, "R4 busy window");
    page_write(8'h00, 2, "R4 busy window");
    random_read(8'hFD, 6);

    // R8: after master NACK, bytes are NACKed until start
    do_start();
    send(CW_R, 1, "R9 current read address");
    expect_tx("R9 current address data");
    mack(1);
    chk(!tx_vld, "R8 no byte after master NACK", tx_vld, 0);
    send(8'h00, 0, "R8 byte after NACK refused");
    do_stop();

    // R9: current address continues after a write
    page_write(8'h8E, 3, "R4 busy window");
    cur_read(2);

    // Random mix
    for (int it = 0; it < 30; it++) begin
      logic [7:0] a;
      a = 8'($urandom);
      wp_en = ($urandom % 5) == 0;
      page_write(a, 1 + ($urandom % 20), wp_en ? "R11 no write cycle when protected"
                                               : "R4 busy window");
      wp_en = 0;
      random_read(8'($urandom), 1 + ($urandom % 18));
      cur_read(1 + ($urandom % 4));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule